// File: doc/BRIEF.md
# Loop-Free Wavefront Allocator

This block pairs N requesters with N resources in one combinational pass. Its input is an N×N request matrix. A requester raises the bit for each resource it would accept. The block returns a grant matrix with at most one grant in each row and at most one in each column. It also returns a flag for each requester that won a resource. A switch or virtual-channel allocator would place it between the request-gathering logic and the crossbar control.

Allocation follows the wavefront method. Work starts on a priority diagonal. Diagonal `d` is the set of cells (row `i`, column `(i+d) mod N`). Cells on one diagonal share no row and no column, so every requested cell on the priority diagonal is granted at once. Each grant then removes the rest of its row and its column. The next diagonals are handled in turn until all N have been covered.

A circular tile array would form a combinational loop. To avoid this, the structure is unrolled into 2N−1 diagonal stages, and a sliding window enables only the N stages that start at the priority diagonal. A small register holds the priority diagonal. It moves forward by one, modulo N, after every cycle that grants anything.

Top module: `wfa_alloc`

## Requirements
- R1: A grant bit `gnt_mat[i*N+j]` is never high unless the matching request bit `req_mat[i*N+j]` is high (requester `i`, resource `j`).
- R2: No requester row carries more than one grant.
- R3: No resource column carries more than one grant.
- R4: Every requested cell on the current priority diagonal is granted. Diagonal `d` contains cells (i, (i+d) mod N).
- R5: The matching is maximal: no request is left whose row and column both lack a grant.
- R6: The grant matrix equals the sequential procedure. Starting at priority diagonal `p`, the procedure visits diagonals p, p+1, …, p+N−1 (mod N). On each diagonal it grants every request whose row and column are still free, then marks those rows and columns as taken.
- R7: `req_won[i]` is high exactly when row `i` of the grant matrix holds a grant.
- R8: After reset the priority diagonal is 0. With every request high, the grant matrix is then the identity.
- R9: The priority diagonal advances by one, modulo N, at the clock edge that ends a cycle with any grant. It holds its value after a cycle with no grant.
- R10: Grants respond to the request matrix in the same cycle, with no register in the path from request to grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the priority register |
| rst_n | input | 1 | Synchronous active-low reset |
| req_mat | input | N*N | Request matrix, bit i*N+j = requester i wants resource j |
| gnt_mat | output | N*N | Grant matrix, same layout as req_mat |
| req_won | output | N | Per-requester granted flag |

## Verification
The bench builds the allocator with N = 3. This makes all 512 request matrices cheap to apply. Each pass over them contains 511 matrices that grant something, which shifts the priority diagonal by one relative to the previous pass. Three consecutive passes therefore apply every matrix under each of the three priority diagonals. An all-ones probe after each idle cycle reads the priority diagonal back through the grant pattern, which confirms both the reset value and that the diagonal holds when nothing is granted.

// File: rtl/wfa_pkg.sv
// Package: shared helpers for the wavefront allocator.
// Assumes the matrix side length is at least 2.
package wfa_pkg;

    // Column index of the cell on diagonal 'diag' in row 'row' for side length 'n'.
    function automatic int diag_col(input int row, input int diag, input int n);
        return (row + diag) % n;
    endfunction

    // Width of an index able to name any of n positions (minimum 1).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wfa_prio_ptr.sv
// Module: wfa_prio_ptr
// Holds the priority diagonal index. Resets to 0 and steps by one modulo N
// when 'advance' is high at a clock edge; otherwise keeps its value.
// Assumes N >= 2.
module wfa_prio_ptr #(
    parameter int N  = 4,
    parameter int PW = wfa_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    // Priority diagonal register with wraparound at N-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr));

    // R8
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

endmodule

// File: rtl/wfa_diag_stage.sv
// Module: wfa_diag_stage
// One diagonal of the unrolled wavefront. It covers diagonal STAGE mod N.
// When enabled, it grants every requested cell whose row and column are
// still free, and it passes the updated free masks on to the next stage.
// Purely combinational. Assumes only this stage touches each of its cells.
module wfa_diag_stage #(
    parameter int N     = 4,
    parameter int STAGE = 0
) (
    input  logic         enable,
    input  logic [N-1:0] req_diag,    // indexed by row
    input  logic [N-1:0] row_free_i,
    input  logic [N-1:0] col_free_i,
    output logic [N-1:0] gnt_diag,    // indexed by row
    output logic [N-1:0] row_free_o,
    output logic [N-1:0] col_free_o
);

    localparam int DIAG = STAGE % N;

    // Grant the free requested cells of this diagonal and update the masks.
    always_comb begin
        row_free_o = row_free_i;
        col_free_o = col_free_i;
        for (int i = 0; i < N; i++) begin
            gnt_diag[i] = enable && req_diag[i] && row_free_i[i]
                          && col_free_i[wfa_pkg::diag_col(i, DIAG, N)];
            if (gnt_diag[i]) begin
                row_free_o[i] = 1'b0;
                col_free_o[wfa_pkg::diag_col(i, DIAG, N)] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/wfa_alloc.sv
// Module: wfa_alloc (top)
// N x N wavefront allocator. The wrapped tile array is unrolled into 2N-1
// diagonal stages, so there is no combinational loop. A window of N stages
// starting at the priority diagonal is enabled. Cell (i,j) is handled by
// stage (j-i) mod N or by that stage plus N; the window enables exactly one
// of the two. The priority diagonal advances after any cycle that grants.
// Assumes N >= 2. Request bit i*N+j is requester i, resource j.
module wfa_alloc #(
    parameter int N  = 4,
    parameter int PW = wfa_pkg::idx_width(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*N-1:0] req_mat,
    output logic [N*N-1:0] gnt_mat,
    output logic [N-1:0]   req_won
);

    localparam int STAGES = 2 * N - 1;

    logic [PW-1:0]     prio;
    logic [STAGES-1:0] stage_on;
    logic [N-1:0]      row_chain [STAGES+1];
    logic [N-1:0]      col_chain [STAGES+1];
    logic [N-1:0]      stage_req [STAGES];
    logic [N-1:0]      stage_gnt [STAGES];

    // Priority diagonal register.
    wfa_prio_ptr #(.N(N), .PW(PW)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (|req_won),
        .ptr     (prio)
    );

    // Sliding window: enable the N stages starting at the priority diagonal.
    always_comb begin
        for (int s = 0; s < STAGES; s++) begin
            stage_on[s] = (s >= int'(prio)) && (s < int'(prio) + N);
        end
    end

    assign row_chain[0] = '1;
    assign col_chain[0] = '1;

    // Build the unrolled diagonal chain.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < N; i++) begin : g_tap
            localparam int COL = (i + (s % N)) % N;
            assign stage_req[s][i] = req_mat[i*N + COL];
        end
        wfa_diag_stage #(.N(N), .STAGE(s)) u_stage (
            .enable     (stage_on[s]),
            .req_diag   (stage_req[s]),
            .row_free_i (row_chain[s]),
            .col_free_i (col_chain[s]),
            .gnt_diag   (stage_gnt[s]),
            .row_free_o (row_chain[s+1]),
            .col_free_o (col_chain[s+1])
        );
    end

    // Fold the two stage copies of each cell into the grant matrix.
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam int D = (j - i + N) % N;
            if (D + N < STAGES) begin : g_two
                assign gnt_mat[i*N + j] = stage_gnt[D][i] | stage_gnt[D + N][i];
            end else begin : g_one
                assign gnt_mat[i*N + j] = stage_gnt[D][i];
            end
        end
        assign req_won[i] = |gnt_mat[i*N +: N];
    end

    // ---------------- checks on the matching ----------------
    logic [N-1:0] row_hit, col_hit;
    logic [N-1:0] col_vec [N];
    logic         left_open;
    logic         diag_miss;

    // Gather per-row and per-column grant views for the checks.
    always_comb begin
        left_open = 1'b0;
        diag_miss = 1'b0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                col_vec[j][i] = gnt_mat[i*N + j];
            end
            col_hit[j] = |col_vec[j];
        end
        for (int i = 0; i < N; i++) begin
            row_hit[i] = |gnt_mat[i*N +: N];
            diag_miss  = diag_miss
                         | (req_mat[i*N + wfa_pkg::diag_col(i, int'(prio), N)]
                            & ~gnt_mat[i*N + wfa_pkg::diag_col(i, int'(prio), N)]);
            for (int j = 0; j < N; j++) begin
                left_open = left_open | (req_mat[i*N + j] & ~row_hit[i] & ~col_hit[j]);
            end
        end
    end

    // R1
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_mat & ~req_mat) == '0);

    // R4
    prio_diag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_miss);

    // R5
    maximal_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_open);

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R2
        one_per_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_mat[k*N +: N]));
        // R3
        one_per_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_vec[k]));
    end

endmodule

// File: tb/wfa_alloc_tb.sv
// Bench for wfa_alloc with N = 3: three exhaustive passes over all request
// matrices plus priority-diagonal probes, against an arithmetic reference.
module wfa_alloc_tb;

    localparam int NR = 3;
    localparam int NB = NR * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req_mat = '0;
    logic [NB-1:0] gnt_mat;
    logic [NR-1:0] req_won;

    int checks = 0;
    int errors = 0;
    int exp_prio = 0;

    always #10 clk = ~clk;

    wfa_alloc #(.N(NR)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_mat (req_mat),
        .gnt_mat (gnt_mat),
        .req_won (req_won)
    );

    // Sequential reference procedure of R6.
    function automatic logic [NB-1:0] ref_gnt(input logic [NB-1:0] rq, input int p);
        logic [NR-1:0] rf = '1;
        logic [NR-1:0] cf = '1;
        logic [NB-1:0] g  = '0;
        for (int k = 0; k < NR; k++) begin
            int d = (p + k) % NR;
            for (int i = 0; i < NR; i++) begin
                int c = (i + d) % NR;
                if (rq[i*NR + c] && rf[i] && cf[c]) begin
                    g[i*NR + c] = 1'b1;
                    rf[i] = 1'b0;
                    cf[c] = 1'b0;
                end
            end
        end
        return g;
    endfunction

    function automatic logic [NB-1:0] diag_mask(input int p);
        logic [NB-1:0] m = '0;
        for (int i = 0; i < NR; i++) m[i*NR + (i + p) % NR] = 1'b1;
        return m;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (req %b prio %0d)",
                     rq, act, exp, req_mat, exp_prio);
        end
    endtask

    // Drive one matrix at the falling edge, check just after, then pass the clock edge.
    task automatic apply(input logic [NB-1:0] rq);
        logic [NB-1:0] e;
        logic [NR-1:0] w;
        logic [NB-1:0] open;
        bit            r2, r3;
        @(negedge clk);
        req_mat = rq;
        #1;
        e = ref_gnt(rq, exp_prio);
        for (int i = 0; i < NR; i++) w[i] = |e[i*NR +: NR];
        // R6 and R10: exact grant matrix in the same cycle
        chk(gnt_mat === e, "R6/R10", gnt_mat, e);
        // R7
        chk(req_won === w, "R7", {{(NB-NR){1'b0}}, req_won}, {{(NB-NR){1'b0}}, w});
        // R1
        chk((gnt_mat & ~rq) == '0, "R1", gnt_mat, gnt_mat & rq);
        r2 = 1'b1;
        r3 = 1'b1;
        open = '0;
        for (int i = 0; i < NR; i++) begin
            int rc = 0;
            int cc = 0;
            for (int j = 0; j < NR; j++) begin
                rc += gnt_mat[i*NR + j];
                cc += gnt_mat[j*NR + i];
            end
            if (rc > 1) r2 = 1'b0;
            if (cc > 1) r3 = 1'b0;
        end
        for (int i = 0; i < NR; i++)
            for (int j = 0; j < NR; j++) begin
                bit rh = 1'b0;
                bit ch = 1'b0;
                for (int k = 0; k < NR; k++) begin
                    rh |= gnt_mat[i*NR + k];
                    ch |= gnt_mat[k*NR + j];
                end
                if (rq[i*NR + j] && !rh && !ch) open[i*NR + j] = 1'b1;
            end
        // R2
        chk(r2, "R2", gnt_mat, e);
        // R3
        chk(r3, "R3", gnt_mat, e);
        // R5
        chk(open == '0, "R5", open, '0);
        // R4
        chk((rq & diag_mask(exp_prio) & ~gnt_mat) == '0, "R4", gnt_mat,
            rq & diag_mask(exp_prio));
        @(posedge clk);
        if (e != '0) exp_prio = (exp_prio + 1) % NR;
    endtask

    // Idle cycle then all-ones probe: reveals the held priority diagonal.
    task automatic probe(input string rq);
        @(negedge clk);
        req_mat = '0;
        #1;
        chk(gnt_mat == '0, rq, gnt_mat, '0);
        @(posedge clk);
        @(negedge clk);
        req_mat = '1;
        #1;
        chk(gnt_mat === diag_mask(exp_prio), rq, gnt_mat, diag_mask(exp_prio));
        @(posedge clk);
        exp_prio = (exp_prio + 1) % NR;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R8: reset state, nothing requested, nothing granted
        chk(gnt_mat == '0 && req_won == '0, "R8", gnt_mat, '0);
        rst_n = 1'b1;
        // R8: all-ones after reset gives the identity (diagonal 0)
        @(negedge clk);
        req_mat = '1;
        #1;
        chk(gnt_mat === diag_mask(0), "R8", gnt_mat, diag_mask(0));
        @(posedge clk);
        exp_prio = 1;
        for (int pass = 0; pass < 3; pass++) begin
            for (int v = 0; v < (1 << NB); v++) apply(NB'(v));
            // R9: diagonal holds over an idle cycle, then advances
            probe("R9");
        end
        for (int k = 0; k < NR; k++) probe("R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule